// File: doc/BRIEF.md
# Reset and Watchdog Sequencing Controller

This block generates the system reset for a small microcontroller-style chip. It runs in the system clock domain and advances its timers only on cycles where a crystal-clock enable (a 32.768 kHz tick) is high. Three sources can reset the core:

- an external active-high reset pin;
- a power-fault comparator that reports the supply below its bias level;
- an independent watchdog that firmware must refresh periodically.

Every reset holds the core for a fixed number of crystal ticks after its source has gone away. The core then leaves reset and starts fetching at its boot address (0x0000).

The block has two reset outputs. `core_rst` resets the core. `io_clr` returns the I/O configuration register bank to its defaults. A pin reset or a power-fault reset drives both outputs. A watchdog reset drives only `core_rst`, so the I/O configuration survives it.

Firmware has no way to stop the watchdog. Two things disable it: a debug-enable input, and a rail-level strap on the power-fault sense input. The rail-level strap also turns off power-fault detection.

A cause register records which source produced the most recent reset.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, `core_rst` and `io_clr` are 1 and `cause` is 00. Both outputs return to 0 on the clock edge that counts the HOLD_TICKS-th `xtal_en` tick after `rst` falls.
- R2: Each of `pin_rst`, `pf_low`, `pf_rail` and `dbg_en` passes through a two-flop synchronizer, so a change is acted on two clocks later. From that point, `pin_rst` high drives `core_rst`=1, `io_clr`=1 and `cause`=01.
- R3: A hold lasts HOLD_TICKS ticks (default 4096), counted from the first tick after every reset source has gone inactive. Ticks that arrive while a source is still active do not count.
- R4: While the core runs and the watchdog is enabled, WD_TICKS consecutive ticks (default 49152, 1.5 s) without a refresh produce an overflow. The overflow sets `core_rst`=1 and `cause`=10 and leaves `io_clr` at 0.
- R5: A refresh is `wd_kick` high in the same cycle as `xtal_en`, and it restarts the watchdog count at zero. `wd_kick` in a cycle without `xtal_en` has no effect.
- R6: A watchdog reset releases after the R3 hold, and `io_clr` stays 0 for the whole of that reset.
- R7: While the synchronized `dbg_en` is 1, the watchdog never overflows.
- R8: While the synchronized `pf_rail` is 1, the watchdog is disabled and `pf_low` is ignored.
- R9: With `pf_rail` at 0, a synchronized `pf_low` of 1 resets like the pin, with `cause`=11 and `io_clr`=1.
- R10: The pin takes priority over a power fault (`cause`=01 when both are active). A pin or power fault that occurs during a watchdog hold turns that reset into a full reset, with `io_clr`=1 and the cause updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset of the controller |
| xtal_en | input | 1 | Crystal-clock tick enable, one cycle wide |
| pin_rst | input | 1 | External reset pin, asynchronous, active high |
| wd_kick | input | 1 | Firmware watchdog refresh strobe |
| dbg_en | input | 1 | Debug enable; disables the watchdog |
| pf_low | input | 1 | Comparator output: supply below bias, asynchronous |
| pf_rail | input | 1 | Sense input strapped to the rail; disables the watchdog and power-fault detection |
| core_rst | output | 1 | Core reset, registered |
| io_clr | output | 1 | I/O configuration bank clear, registered |
| cause | output | 2 | Last reset cause: 00 power-on, 01 pin, 10 watchdog, 11 power fault |

## Verification
A hold counter that is off by even one tick moves the falling edge of `core_rst` by one tick period. The bench compares the outputs on every clock, so it sees that error on the first release.

A watchdog count that is not cleared by a refresh, or that is wrongly cleared by a stray strobe, changes when the overflow occurs. Either fault appears as a `core_rst` rise in the wrong cycle within one watchdog period.

A wrong choice of source priority, or a wrong keep-or-clear decision, shows on `io_clr` and `cause` two clocks after the stimulus reaches the synchronizers.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR   = 2'b00,
    CAUSE_PIN   = 2'b01,
    CAUSE_WDOG  = 2'b10,
    CAUSE_PFAIL = 2'b11
  } cause_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
  parameter int WD_TICKS = 49152
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic off,
  input  logic tick,
  input  logic kick,
  output logic bite
);
  localparam int CW = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  logic [CW-1:0] cnt;

  assign bite = run && !off && tick && !kick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run || off || bite || (tick && kick)) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_hold.sv
module rstseq_hold
  import rstseq_pkg::*;
#(
  parameter int HOLD_TICKS = 4096
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   pin_act,
  input  logic   pf_act,
  input  logic   wd_bite,
  output logic   core_rst,
  output logic   io_clr,
  output cause_e cause
);
  localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst <= 1'b1;
      io_clr   <= 1'b1;
      cause    <= CAUSE_POR;
      hcnt     <= '0;
    end else if (pin_act || pf_act) begin
      core_rst <= 1'b1;
      io_clr   <= 1'b1;
      cause    <= pin_act ? CAUSE_PIN : CAUSE_PFAIL;
      hcnt     <= '0;
    end else if (core_rst) begin
      if (tick) begin
        if (hcnt == HOLD_LAST) begin
          core_rst <= 1'b0;
          io_clr   <= 1'b0;
          hcnt     <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end else if (wd_bite) begin
      core_rst <= 1'b1;
      cause    <= CAUSE_WDOG;
      hcnt     <= '0;
    end
  end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int HOLD_TICKS = 4096,
  parameter int WD_TICKS   = 49152
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xtal_en,
  input  logic       pin_rst,
  input  logic       wd_kick,
  input  logic       dbg_en,
  input  logic       pf_low,
  input  logic       pf_rail,
  output logic       core_rst,
  output logic       io_clr,
  output logic [1:0] cause
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic   pin_s, pf_low_s, pf_rail_s, dbg_s;
  logic   pf_act, wd_off, wd_bite;
  cause_e cause_q;

  assign raw_in = {dbg_en, pf_rail, pf_low, pin_rst};
  assign {dbg_s, pf_rail_s, pf_low_s, pin_s} = syn_in;

  rstseq_sync #(.WIDTH(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign pf_act = pf_low_s && !pf_rail_s;
  assign wd_off = dbg_s || pf_rail_s;

  rstseq_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
    .clk  (clk),
    .rst  (rst),
    .run  (!core_rst),
    .off  (wd_off),
    .tick (xtal_en),
    .kick (wd_kick),
    .bite (wd_bite)
  );

  rstseq_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .tick     (xtal_en),
    .pin_act  (pin_s),
    .pf_act   (pf_act),
    .wd_bite  (wd_bite),
    .core_rst (core_rst),
    .io_clr   (io_clr),
    .cause    (cause_q)
  );

  assign cause = cause_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       xtal_en,
  input logic       pin_s,
  input logic       pf_act,
  input logic       wd_off,
  input logic       core_rst,
  input logic       io_clr,
  input logic [1:0] cause
);
  assert_ioclr_with_core_R2: assert property (@(posedge clk) disable iff (rst)
    io_clr |-> core_rst);

  assert_wdog_keeps_io_R4: assert property (@(posedge clk) disable iff (rst)
    (core_rst && cause == 2'b10) |-> !io_clr);

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> $past(xtal_en));

  assert_pin_resets_R2: assert property (@(posedge clk) disable iff (rst)
    pin_s |=> (core_rst && io_clr && cause == 2'b01));

  assert_pfail_resets_R9: assert property (@(posedge clk) disable iff (rst)
    (pf_act && !pin_s) |=> (core_rst && io_clr && cause == 2'b11));

  assert_wdog_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!core_rst && wd_off && !pin_s && !pf_act) |=> !core_rst);
endmodule

bind rstseq_ctrl rstseq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .xtal_en  (xtal_en),
  .pin_s    (pin_s),
  .pf_act   (pf_act),
  .wd_off   (wd_off),
  .core_rst (core_rst),
  .io_clr   (io_clr),
  .cause    (cause)
);

// File: tb/sim_rstseq_ctrl.sv
`timescale 1ns/1ps
module sim_rstseq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int WD   = 40;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xtal_en = 1'b0, pin_rst = 1'b0, wd_kick = 1'b0;
  logic dbg_en = 1'b0, pf_low = 1'b0, pf_rail = 1'b0;
  logic core_rst, io_clr;
  logic [1:0] cause;

  int checks = 0, fails = 0, cyc = 0;
  bit kick_on = 1'b0, stray_on = 1'b0, done = 1'b0;
  string phase = "R1";

  rstseq_ctrl #(.HOLD_TICKS(HOLD), .WD_TICKS(WD)) u0 (
    .clk(clk), .rst(rst), .xtal_en(xtal_en), .pin_rst(pin_rst),
    .wd_kick(wd_kick), .dbg_en(dbg_en), .pf_low(pf_low), .pf_rail(pf_rail),
    .core_rst(core_rst), .io_clr(io_clr), .cause(cause));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit m_core = 1'b1, m_io = 1'b1;
  int m_cause = 0, m_hold = 0, m_wd = 0;
  bit [3:0] q1 = '0, q2 = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_core = 1'b1; m_io = 1'b1; m_cause = 0; m_hold = 0; m_wd = 0;
      q1 = '0; q2 = '0;
    end else begin
      bit s_pin, s_pf, s_off;
      s_pin = q2[0];
      s_pf  = q2[1] && !q2[2];
      s_off = q2[3] || q2[2];
      if (s_pin || s_pf) begin
        m_core = 1'b1; m_io = 1'b1; m_cause = s_pin ? 1 : 3; m_hold = 0; m_wd = 0;
      end else if (m_core) begin
        m_wd = 0;
        if (xtal_en) begin
          if (m_hold == HOLD - 1) begin
            m_core = 1'b0; m_io = 1'b0; m_hold = 0;
          end else m_hold++;
        end
      end else if (s_off || (xtal_en && wd_kick)) begin
        m_wd = 0;
      end else if (xtal_en) begin
        if (m_wd == WD - 1) begin
          m_core = 1'b1; m_cause = 2; m_wd = 0; m_hold = 0;
        end else m_wd++;
      end
      q2 = q1;
      q1 = {dbg_en, pf_rail, pf_low, pin_rst};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // stimulus generator for ticks and kicks, plus per-cycle compare
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      check(core_rst == m_core, {phase, " core_rst"}, core_rst, m_core);
      check(io_clr == m_io, {phase, " io_clr"}, io_clr, m_io);
      check(int'(cause) == m_cause, {phase, " cause"}, cause, m_cause);
    end
    xtal_en = (cyc % TICK_DIV == 0);
    wd_kick = (kick_on && xtal_en && ((cyc / TICK_DIV) % 8 == 0)) ||
              (stray_on && (cyc % TICK_DIV == 1));
    if (cyc > 100000 && !done) begin
      check(1'b0, "watchdog timeout", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_core(input bit v, input int lim, input string req);
    int k = 0;
    while (core_rst != v && k < lim) begin @(negedge clk); k++; end
    check(core_rst == v, req, core_rst, v);
  endtask

  initial begin
    wait_cyc(4);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(core_rst && io_clr && cause == 2'b00, "R1 por state", {core_rst, io_clr, cause}, 4'b1100);
    wait_core(1'b0, 200, "R1 por release");

    phase = "R5"; kick_on = 1'b1; stray_on = 1'b0;
    wait_cyc(400);
    check(core_rst == 1'b0, "R5 refresh keeps running", core_rst, 0);

    phase = "R4"; kick_on = 1'b0; stray_on = 1'b1;
    wait_core(1'b1, 400, "R4 overflow (stray kicks ignored R5)");
    check(io_clr == 1'b0 && cause == 2'b10, "R4 keep io, cause wdog", {io_clr, cause}, 3'b010);
    phase = "R6"; stray_on = 1'b0; kick_on = 1'b1;
    begin
      bit io_seen = 1'b0;
      int k = 0;
      while (core_rst && k < 200) begin @(negedge clk); io_seen |= io_clr; k++; end
      check(!core_rst && !io_seen, "R6 wdog release keeps io", {core_rst, io_seen}, 0);
    end

    phase = "R7"; kick_on = 1'b0; dbg_en = 1'b1;
    wait_cyc(500);
    check(core_rst == 1'b0, "R7 debug disables watchdog", core_rst, 0);
    kick_on = 1'b1; wait_cyc(6); dbg_en = 1'b0;

    phase = "R8"; kick_on = 1'b0; pf_rail = 1'b1; wait_cyc(4);
    pf_low = 1'b1; wait_cyc(30); pf_low = 1'b0;
    wait_cyc(470);
    check(core_rst == 1'b0, "R8 rail strap disables wdog and fault", core_rst, 0);
    kick_on = 1'b1; wait_cyc(6); pf_rail = 1'b0; wait_cyc(6);

    phase = "R9"; pf_low = 1'b1; wait_cyc(10);
    check(core_rst && io_clr && cause == 2'b11, "R9 power fault reset", {core_rst, io_clr, cause}, 4'b1111);
    pf_low = 1'b0;
    wait_core(1'b0, 200, "R9 release");

    phase = "R2"; pin_rst = 1'b1; wait_cyc(3);
    check(core_rst && io_clr && cause == 2'b01, "R2 pin reset", {core_rst, io_clr, cause}, 4'b1101);
    phase = "R3"; wait_cyc(60);
    check(core_rst == 1'b1, "R3 no count while pin high", core_rst, 1);
    pin_rst = 1'b0; wait_cyc(2 + HOLD * TICK_DIV - 4);
    check(core_rst == 1'b1, "R3 still held before hold end", core_rst, 1);
    wait_cyc(8);
    check(core_rst == 1'b0, "R3 released after hold", core_rst, 0);

    phase = "R10"; kick_on = 1'b0;
    wait_core(1'b1, 400, "R10 wdog overflow");
    wait_cyc(5); pin_rst = 1'b1; pf_low = 1'b1; wait_cyc(4);
    check(io_clr && cause == 2'b01, "R10 pin over fault during wdog hold", {io_clr, cause}, 3'b101);
    pin_rst = 1'b0; wait_cyc(6);
    check(io_clr && cause == 2'b11, "R10 fault after pin", {io_clr, cause}, 3'b111);
    pf_low = 1'b0; kick_on = 1'b1;
    wait_core(1'b0, 200, "R10 release");
    wait_cyc(20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule